// File: doc/BRIEF.md
# Macrocell Arithmetic Carry Chain

This block adds a ripple carry path across the macrocells of one logic block, so that those cells can act together as an adder or a subtractor. Each cell takes two operand bits from its OR-plane outputs and returns one sum bit. Cells are linked in index order. The carry leaving the last cell is exported so that a following block can extend the chain.

A per-cell use mask chooses which cells take part in the arithmetic. A cell that is left out passes the carry it receives on to the next cell unchanged. This lets an arithmetic field continue past cells that hold unrelated logic. The carry into cell 0 comes from a two-bit source select: constant zero, constant one, or the carry out of a neighbouring block.

To subtract, the user supplies the inverted second operand and selects constant one as the first carry. The result is the two's complement difference.

Top module: `carry_chain`

## Requirements
- R1: With every cell enabled, {cout, sum} equals op_a + op_b + initial carry as unsigned N-bit integers.
- R2: cin_sel = 2'b00 forces the initial carry to 0.
- R3: cin_sel = 2'b01 forces the initial carry to 1.
- R4: cin_sel = 2'b10 takes the initial carry from nbr_cout.
- R5: cin_sel = 2'b11 is reserved and behaves as constant 0.
- R6: A cell whose use_mask bit is 0 drives its sum bit to 0 and passes its incoming carry unchanged to the next cell.
- R7: For any use mask, the enabled cells, taken in ascending index order, form one adder of their packed bits plus the initial carry. Sum bit k of that addition appears at the k-th enabled cell, and bit (count of enabled cells) of it appears on cout.
- R8: With op_b inverted, cin_sel = 2'b01 and all cells enabled, sum equals op_a - op_b modulo 2^N, and cout is 1 exactly when op_a >= op_b.
- R9: When the highest cell is enabled and both of its operand bits are 1, cout is 1. When both are 0, cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand bit of each cell |
| op_b | input | N | Second operand bit of each cell |
| use_mask | input | N | 1 = cell takes part in arithmetic, 0 = carry bypass |
| cin_sel | input | 2 | Initial carry source: 00 zero, 01 one, 10 neighbour, 11 zero |
| nbr_cout | input | 1 | Carry out of the neighbouring block |
| sum | output | N | Sum bit per cell, 0 for bypassed cells |
| cout | output | 1 | Carry leaving the last cell |

## Verification
The embedded assertions check the following on every evaluation:
- a fully enabled chain matches a single wide addition;
- an all-bypass chain carries a neighbour or reserved select straight to cout;
- adding an operand to its own complement wraps to zero with a carry out;
- the top cell's generate and kill conditions set cout.

Partial masks with bypassed cells between enabled ones, and borrow behaviour on subtraction over random operands, appear only in the bench scenarios. There, a packed-integer reference is compared against each cell's sum bit.

// File: rtl/carry_chain.sv
module carry_chain #(
  parameter int N = 32
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] use_mask,
  input  logic [1:0]   cin_sel,
  input  logic         nbr_cout,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam logic [1:0] SEL_ZERO = 2'b00;
  localparam logic [1:0] SEL_ONE  = 2'b01;
  localparam logic [1:0] SEL_NBR  = 2'b10;

  logic [N:0] c;

  always_comb begin
    case (cin_sel)
      SEL_ONE: c[0] = 1'b1;
      SEL_NBR: c[0] = nbr_cout;
      default: c[0] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic s_raw, c_gen;
    assign s_raw    = op_a[i] ^ op_b[i] ^ c[i];
    assign c_gen    = (op_a[i] & op_b[i]) | (c[i] & (op_a[i] ^ op_b[i]));
    assign sum[i]   = use_mask[i] & s_raw;
    assign c[i+1]   = use_mask[i] ? c_gen : c[i];
  end

  assign cout = c[N];

  logic [N:0] wide_ref;
  assign wide_ref = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, (cin_sel == SEL_ONE) | ((cin_sel == SEL_NBR) & nbr_cout)};

  always_comb begin
    if (&use_mask)
      p_full_add_r1: assert ({cout, sum} == wide_ref);
    if (use_mask == '0 && cin_sel == SEL_NBR)
      p_bypass_nbr_r6: assert (cout == nbr_cout);
    if (use_mask == '0 && cin_sel == 2'b11)
      p_reserved_zero_r5: assert (!cout);
    if (&use_mask && cin_sel == SEL_ONE && op_b == ~op_a)
      p_self_sub_r8: assert (sum == '0 && cout);
    if (use_mask[N-1] && op_a[N-1] && op_b[N-1])
      p_top_gen_r9: assert (cout);
    if (use_mask[N-1] && !op_a[N-1] && !op_b[N-1])
      p_top_kill_r9: assert (!cout);
    if (cin_sel == SEL_ZERO && (op_a | op_b) == '0)
      p_zero_in_r2: assert (sum == '0 && !cout);
  end
endmodule

// File: tb/tb_carry_chain.sv
module tb_carry_chain;
  localparam int N = 32;
  localparam time PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [N-1:0] op_a, op_b, use_mask, sum;
  logic [1:0] cin_sel;
  logic nbr_cout, cout;
  int vectors = 0, misses = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  carry_chain #(.N(N)) dut (.op_a(op_a), .op_b(op_b), .use_mask(use_mask),
    .cin_sel(cin_sel), .nbr_cout(nbr_cout), .sum(sum), .cout(cout));

  function automatic void model(input logic [N-1:0] a, b, u, input logic [1:0] sel,
                                input logic nb, output logic [N-1:0] es, output logic ec);
    longint unsigned pa = 0, pb = 0, tot;
    int k = 0;
    logic ci;
    ci = (sel == 2'b01) ? 1'b1 : (sel == 2'b10) ? nb : 1'b0;
    for (int i = 0; i < N; i++) if (u[i]) begin
      pa |= longint'(a[i]) << k; pb |= longint'(b[i]) << k; k++;
    end
    tot = pa + pb + longint'(ci);
    es = '0; k = 0;
    for (int i = 0; i < N; i++) if (u[i]) begin es[i] = tot[k]; k++; end
    ec = tot[k];
  endfunction

  task automatic apply(input logic [N-1:0] a, b, u, input logic [1:0] sel,
                       input logic nb, input string tag);
    logic [N-1:0] es; logic ec;
    @(posedge clk);
    op_a = a; op_b = b; use_mask = u; cin_sel = sel; nbr_cout = nb;
    model(a, b, u, sel, nb, es, ec);
    @(negedge clk);
    vectors++;
    if (sum !== es || cout !== ec) begin
      misses++;
      $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b", tag, sum, cout, es, ec);
    end
  endtask

  initial begin
    op_a = '0; op_b = '0; use_mask = '0; cin_sel = 2'b00; nbr_cout = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    apply('0, '0, '1, 2'b00, 1'b0, "R2");
    apply('1, 32'h1, '1, 2'b00, 1'b0, "R1");
    apply(32'h1234_5678, 32'h0fed_cba9, '1, 2'b00, 1'b1, "R2");
    apply('1, '0, '1, 2'b01, 1'b0, "R3");
    apply(32'h8000_0000, '0, '1, 2'b10, 1'b1, "R4");
    apply('1, '0, '1, 2'b10, 1'b1, "R4");
    apply('1, '0, '1, 2'b11, 1'b1, "R5");
    apply('1, '1, '0, 2'b10, 1'b1, "R6");
    apply('1, '1, '0, 2'b01, 1'b0, "R6");
    apply('1, '0, '0, 2'b11, 1'b1, "R5");
    apply(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 2'b00, 1'b0, "R9");
    apply(32'h7fff_ffff, 32'h0000_0001, 32'h8000_0001, 2'b00, 1'b0, "R9");
    apply('1, 32'h1, 32'h5555_5555, 2'b00, 1'b0, "R7");
    for (int n = 0; n < 1500; n++)
      apply($urandom, $urandom, $urandom, 2'($urandom), 1'($urandom), "R7");
    for (int n = 0; n < 500; n++) begin
      logic [N-1:0] a, b;
      a = $urandom; b = (n % 7 == 0) ? a : $urandom;
      @(posedge clk);
      op_a = a; op_b = ~b; use_mask = '1; cin_sel = 2'b01; nbr_cout = 0;
      @(negedge clk);
      vectors++;
      if (sum !== a - b || cout !== (a >= b)) begin
        misses++;
        $display("FAIL R8: sum=%h cout=%b expected sum=%h cout=%b", sum, cout, a - b, a >= b);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule